// File: doc/BRIEF.md
# Host Ready Flag Controller

This block drives a single advisory ready line toward a serial host. In write mode the line follows the fill level of the receive FIFO with hysteresis: it drops when the FIFO is nearly full and rises again once the host's data has drained. In read mode it follows transmit-side events instead. The first byte of a read command pulls it low. A full transmit bank raises it so the host can fetch. The bank being read running empty pulls it low again.

Every low phase lasts a guaranteed minimum time. An inactivity timer watches the bytes arriving for transmission. When no new byte comes within the timeout, the line is forced high, or pulsed low and back high if it was already high. All delays are derived from a clock-frequency parameter. The line is status only: no data path passes through the block.

Top module: `host_ready_ctrl`

## Requirements
- R1: After reset `ready_o` is 1, write mode rules apply and the inactivity timer is idle.
- R2: With `read_mode_i` = 0 and `ready_o` = 1, a `rx_level_i` of 16 or more drives `ready_o` to 0 on the next clock edge.
- R3: With `read_mode_i` = 0, after a fill-level drop `ready_o` stays 0 while `rx_level_i` is between 8 and 15. Once `rx_level_i` is below 8 it rises on the next edge, provided the minimum low time is over.
- R4: With `read_mode_i` = 1, a pulse on `rd_cmd_first_i` drives `ready_o` to 0 on the next edge.
- R5: With `read_mode_i` = 1, a pulse on `bank_full_i` drives `ready_o` to 1 on the next edge once the minimum low time is over. A pulse that arrives during that time is remembered.
- R6: With `read_mode_i` = 1, a pulse on `bank_empty_i` drives `ready_o` to 0 on the next edge.
- R7: Each low phase of `ready_o` lasts at least MIN_LOW_NS (2 µs, 400 cycles at 200 MHz). With a pending rise it lasts exactly that long.
- R8: The timer is armed by `rd_cmd_first_i` in read mode and restarts on each `tx_byte_i`. When TIMEOUT_NS (30 µs, 6000 cycles at 200 MHz) pass without a new byte, it expires and `ready_o` is 1 on the edge that lies that many cycles after the last byte's edge.
- R9: An expiry while `ready_o` is 1 drops it to 0 for exactly the minimum low time, then it returns to 1.
- R10: While `read_mode_i` = 1, `rx_level_i` has no effect on `ready_o`.
- R11: In read mode, when a rise request (bank full or expiry) and a fall request (bank empty or read command) hit the same edge, the rise wins.
- R12: Clearing `read_mode_i` disarms the timer: no expiry and no pulse follow the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| read_mode_i | input | 1 | 1 = host read sequence in progress |
| rx_level_i | input | LVL_W | Receive FIFO byte count |
| rd_cmd_first_i | input | 1 | Pulse: first byte of a read command received |
| bank_full_i | input | 1 | Pulse: a transmit bank became full |
| bank_empty_i | input | 1 | Pulse: the transmit bank being read became empty |
| tx_byte_i | input | 1 | Pulse: a byte arrived for transmission |
| ready_o | output | 1 | Advisory ready flag to the host |

## Verification
The timer expiry and a bank-empty pulse can land on the same edge, and they ask for opposite levels. The bench provokes this by sending one transmit byte while the flag is low and the hold is over. It then places the bank-empty pulse exactly on the edge where the timeout count ends. The flag must come out high on that edge. A second pairing, bank full and bank empty in one cycle, is driven from the vector table with the same expected result.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

  // ceil(hz * ns / 1e9), at least 2 cycles
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  typedef struct packed {
    logic want;   // next requested level
    logic force_; // timeout pulse request
  } hrc_req_t;

endpackage

// File: rtl/hrc_idle_timer.sv
module hrc_idle_timer #(
  parameter int unsigned TMO_CYC = 6000,
  localparam int unsigned CNT_W  = $clog2(TMO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_mode_i,
  input  logic arm_i,
  input  logic byte_i,
  output logic expire_o
);

  logic             armed_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             byte_ok;

  assign byte_ok  = byte_i && read_mode_i && (armed_q || arm_i);
  assign expire_o = read_mode_i && run_q && !byte_ok && (cnt_q == CNT_W'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           armed_q <= 1'b0;
    else if (!read_mode_i) armed_q <= 1'b0;
    else if (arm_i)        armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!read_mode_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (byte_ok) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: a fresh byte pushes expiry a full window away
  a_r8_quiet_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ok |=> !expire_o);

  // R12: leaving read mode stops the count
  a_r12_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_mode_i |=> !run_q && !armed_q);

endmodule

// File: rtl/hrc_level_policy.sv
module hrc_level_policy
  import hrc_pkg::*;
#(
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned HI_LVL = 16,
  parameter int unsigned LO_LVL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rd_cmd_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  logic             expire_i,
  output hrc_req_t         req_o
);

  logic want_q, want_d;
  logic rise_req, fall_req;

  assign rise_req = full_i || expire_i;
  assign fall_req = rd_cmd_i || empty_i;

  always_comb begin
    want_d = want_q;
    if (read_mode_i) begin
      if (rise_req)      want_d = 1'b1;  // rise wins
      else if (fall_req) want_d = 1'b0;
    end else begin
      if (rx_level_i >= LVL_W'(HI_LVL))     want_d = 1'b0;
      else if (rx_level_i < LVL_W'(LO_LVL)) want_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) want_q <= 1'b1;
    else         want_q <= want_d;
  end

  assign req_o.want   = want_d;
  assign req_o.force_ = read_mode_i && expire_i;

  // R10: fill level is ignored in read mode
  a_r10_level_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_mode_i && !rd_cmd_i && !full_i && !empty_i && !expire_i) |=> $stable(want_q));

  // R3: hysteresis band keeps the request
  a_r3_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!read_mode_i && rx_level_i >= LVL_W'(LO_LVL) && rx_level_i < LVL_W'(HI_LVL))
    |=> $stable(want_q));

  // R11: rise request dominates
  a_r11_rise_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_mode_i && (full_i || expire_i)) |=> want_q);

endmodule

// File: rtl/hrc_low_hold.sv
module hrc_low_hold
  import hrc_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 400,
  localparam int unsigned HOLD_W     = $clog2(MIN_LOW_CYC + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  hrc_req_t req_i,
  output logic     ready_o
);

  logic              ready_q, ready_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  always_comb begin
    ready_d = ready_q;
    hold_d  = hold_q;
    if (ready_q) begin
      if (!req_i.want || req_i.force_) begin
        ready_d = 1'b0;
        hold_d  = HOLD_W'(MIN_LOW_CYC - 1);
      end
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else if (req_i.want) begin
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      hold_q  <= '0;
    end else begin
      ready_q <= ready_d;
      hold_q  <= hold_d;
    end
  end

  assign ready_o = ready_q;

  // R7: no residual hold while high
  a_r7_hold_clear_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> hold_q == '0);

  // R9: timeout pulse drops a high flag
  a_r9_force_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && req_i.force_) |=> !ready_q);

endmodule

// File: rtl/host_ready_ctrl.sv
module host_ready_ctrl
  import hrc_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned LVL_W       = 6,
  parameter int unsigned HI_LVL      = 16,
  parameter int unsigned LO_LVL      = 8,
  parameter int unsigned MIN_LOW_NS  = 2_000,
  parameter int unsigned TIMEOUT_NS  = 30_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rd_cmd_first_i,
  input  logic             bank_full_i,
  input  logic             bank_empty_i,
  input  logic             tx_byte_i,
  output logic             ready_o
);

  localparam int unsigned MIN_LOW_CYC = ns_to_cyc(CLK_HZ, MIN_LOW_NS);
  localparam int unsigned TMO_CYC     = ns_to_cyc(CLK_HZ, TIMEOUT_NS);
  localparam int unsigned LOWC_W      = $clog2(MIN_LOW_CYC + 1);

  logic     expire;
  hrc_req_t req;

  hrc_idle_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .read_mode_i(read_mode_i),
    .arm_i      (rd_cmd_first_i),
    .byte_i     (tx_byte_i),
    .expire_o   (expire)
  );

  hrc_level_policy #(.LVL_W(LVL_W), .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)) u_policy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .read_mode_i(read_mode_i),
    .rx_level_i (rx_level_i),
    .rd_cmd_i   (rd_cmd_first_i),
    .full_i     (bank_full_i),
    .empty_i    (bank_empty_i),
    .expire_i   (expire),
    .req_o      (req)
  );

  hrc_low_hold #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .ready_o(ready_o)
  );

  // checker: length of the current low phase, saturating
  logic [LOWC_W-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               low_cnt_q <= '0;
    else if (ready_o)                          low_cnt_q <= '0;
    else if (low_cnt_q != LOWC_W'(MIN_LOW_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R7: every low phase meets the minimum
  a_r7_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> low_cnt_q == LOWC_W'(MIN_LOW_CYC));

  // R2: fill threshold drops the flag in write mode
  a_r2_fill_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!read_mode_i && ready_o && rx_level_i >= LVL_W'(HI_LVL)) |=> !ready_o);

  // R4 / R6: read-side fall requests act on a high flag
  a_r4_r6_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_mode_i && ready_o && (rd_cmd_first_i || bank_empty_i) && !bank_full_i && !expire)
    |=> !ready_o);

endmodule

// File: tb/host_ready_ctrl_bench.sv
`timescale 1ns/1ps
module host_ready_ctrl_bench;

  localparam int M = 200_000_000 / 500_000;        // 2 us at 200 MHz
  localparam int T = 200_000_000 / 1_000_000 * 30; // 30 us at 200 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_mode = 1'b0;
  logic [5:0] rx_lvl = '0;
  logic       rd_cmd = 1'b0, full = 1'b0, empty = 1'b0, tx_byte = 1'b0;
  logic       ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_ready_ctrl u_host_ready_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .read_mode_i   (rd_mode),
    .rx_level_i    (rx_lvl),
    .rd_cmd_first_i(rd_cmd),
    .bank_full_i   (full),
    .bank_empty_i  (empty),
    .tx_byte_i     (tx_byte),
    .ready_o       (ready)
  );

  typedef struct packed {
    logic        rd;
    logic [5:0]  rx;
    logic        cmd;
    logic        full;
    logic        empty;
    logic [15:0] wt;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'd5,  1'b0, 1'b0, 1'b0, 16'd1,           1'b1, 4'd2},  // R2 below
    '{1'b0, 6'd15, 1'b0, 1'b0, 1'b0, 16'd1,           1'b1, 4'd2},  // R2 edge-1
    '{1'b0, 6'd16, 1'b0, 1'b0, 1'b0, 16'd1,           1'b0, 4'd2},  // R2 drop
    '{1'b0, 6'd10, 1'b0, 1'b0, 1'b0, 16'(M + 5),      1'b0, 4'd3},  // R3 band
    '{1'b0, 6'd7,  1'b0, 1'b0, 1'b0, 16'd1,           1'b1, 4'd3},  // R3 rise
    '{1'b0, 6'd8,  1'b0, 1'b0, 1'b0, 16'd1,           1'b1, 4'd3},  // R3 band high
    '{1'b0, 6'd20, 1'b0, 1'b0, 1'b0, 16'd1,           1'b0, 4'd2},  // R2
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 16'd1,           1'b0, 4'd7},  // R7 hold
    '{1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 16'(M),          1'b1, 4'd7},  // R7 release
    '{1'b1, 6'd0,  1'b1, 1'b0, 1'b0, 16'd1,           1'b0, 4'd4},  // R4
    '{1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 16'(M + 2),      1'b0, 4'd10}, // R10
    '{1'b1, 6'd0,  1'b0, 1'b1, 1'b0, 16'd1,           1'b1, 4'd5},  // R5
    '{1'b1, 6'd30, 1'b0, 1'b0, 1'b0, 16'd2,           1'b1, 4'd10}, // R10
    '{1'b1, 6'd0,  1'b0, 1'b0, 1'b1, 16'd1,           1'b0, 4'd6},  // R6
    '{1'b1, 6'd0,  1'b0, 1'b1, 1'b0, 16'd1,           1'b0, 4'd7},  // R7 full in hold
    '{1'b1, 6'd0,  1'b0, 1'b0, 1'b0, 16'(M),          1'b1, 4'd5},  // R5 remembered
    '{1'b1, 6'd0,  1'b0, 1'b0, 1'b1, 16'(M + 2),      1'b0, 4'd6},  // R6
    '{1'b1, 6'd0,  1'b0, 1'b1, 1'b1, 16'd1,           1'b1, 4'd11}, // R11
    '{1'b0, 6'd3,  1'b0, 1'b0, 1'b0, 16'd1,           1'b1, 4'd1}   // R1 write mode back
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ready_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_byte();
    tx_byte = 1'b1;
    step(1);
    tx_byte = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
    end
  end

  initial begin
    step(3);
    check("R1", ready, 1'b1);
    rst_n = 1'b1;
    step(2);
    check("R1", ready, 1'b1);

    for (int i = 0; i < NV; i++) begin
      rd_mode = VEC[i].rd;
      rx_lvl  = VEC[i].rx;
      rd_cmd  = VEC[i].cmd;
      full    = VEC[i].full;
      empty   = VEC[i].empty;
      step(1);
      rd_cmd = 1'b0; full = 1'b0; empty = 1'b0;
      step(int'(VEC[i].wt) - 1);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), ready, VEC[i].exp);
    end

    // R7 exact boundary of the low phase
    rx_lvl = 6'd20;
    step(1);
    rx_lvl = 6'd0;
    check("R7 fall", ready, 1'b0);
    step(M - 1);
    check("R7 last low cycle", ready, 1'b0);
    step(1);
    check("R7 first high cycle", ready, 1'b1);

    // R8 timeout with restart
    rd_mode = 1'b1;
    rd_cmd = 1'b1;
    step(1);
    rd_cmd = 1'b0;
    step(M + 2);
    check("R4 armed low", ready, 1'b0);
    pulse_byte();
    step(T / 2 - 1);
    pulse_byte();
    step(T - 1);
    check("R8 restart no early expiry", ready, 1'b0);
    step(1);
    check("R8 expiry raises", ready, 1'b1);

    // R9 timeout while high
    pulse_byte();
    step(T - 1);
    check("R9 still high", ready, 1'b1);
    step(1);
    check("R9 pulse low", ready, 1'b0);
    step(M - 1);
    check("R9 low held", ready, 1'b0);
    step(1);
    check("R9 back high", ready, 1'b1);

    // R11 expiry and bank empty on the same edge
    empty = 1'b1;
    step(1);
    empty = 1'b0;
    step(M + 2);
    check("R6 low before race", ready, 1'b0);
    pulse_byte();
    step(T - 1);
    empty = 1'b1;
    step(1);
    empty = 1'b0;
    check("R11 expiry beats empty", ready, 1'b1);

    // R12 leaving read mode disarms the timer
    pulse_byte();
    rd_mode = 1'b0;
    rx_lvl = 6'd0;
    begin
      int lows = 0;
      for (int k = 0; k < T + 20; k++) begin
        step(1);
        if (ready !== 1'b1) lows++;
      end
      n_chk++;
      if (lows != 0) begin
        n_fail++;
        $display("FAIL R12: %0d low cycles after disarm, expected 0", lows);
      end
    end

    // R1 reset mid-run
    rx_lvl = 6'd25;
    step(1);
    check("R2 low before reset", ready, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", ready, 1'b1);
    rx_lvl = 6'd0;
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R1 after reset", ready, 1'b1);

    done = 1'b1;
    finish_run();
  end

endmodule